// File: doc/BRIEF.md
# L2 Way-Enable Steering Queue

This block sits between a write-through L1 data cache and a 4-way set-associative L2. Under write-through every L1 store becomes an L2 write, so the block keeps a short queue of way codes that runs in lockstep with the L1-to-L2 write buffer. Both are pushed and popped by the same controls. Each queue entry holds the 2-bit L2 way code of the line and a flag telling whether the store hit in L1. The way is only known when the store hit.

When the write buffer issues its head entry to L2, the block turns that entry into per-way enable lines. A hit entry lights exactly one way, so L2 behaves like a direct-mapped array for that access. A miss entry lights all four ways. An L1 read miss serviced from L2 also lights all four ways. A read miss wins over a buffered write in the same cycle. The write stays at the head of the queue for a later cycle.

Top module: `l2_way_steer`

## Requirements
- R1: After synchronous reset the queue is empty: `q_empty`=1, `q_full`=0 and `way_en`=4'b0000.
- R2: When `wr_issue` is high, `rd_miss` is low and the queue is not empty, and the head entry's hit flag is 1, `way_en` equals 1 shifted left by the head's way code (code 0 selects bit 0, code 3 selects bit 3) in the same cycle.
- R3: Under the conditions of R2 with a head hit flag of 0, `way_en` is 4'b1111 whatever the stored code.
- R4: While `rd_miss` is high, `way_en` is 4'b1111.
- R5: With `rd_miss` low and no write issued (`wr_issue` low, or the queue empty), `way_en` is 4'b0000.
- R6: Entries are issued in push order. The queue holds DEPTH entries (default 4). `q_full` is high exactly when DEPTH entries are held, and `q_empty` is high exactly when none are held.
- R7: A push while full, with no accepted pop in the same cycle, is ignored: occupancy and stored entries are unchanged.
- R8: `wr_issue` while empty is ignored: the queue stays empty, and a later push is issued normally.
- R9: A push and an accepted pop in the same cycle leave the occupancy unchanged. This includes the full case, where the push is accepted.
- R10: When `rd_miss` and `wr_issue` are high together, the head entry is not removed and is issued unchanged on a later `wr_issue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_push | input | 1 | Write buffer accepts a store; enqueue a way entry |
| push_code | input | 2 | L2 way code of the stored line |
| push_hit | input | 1 | Store hit in L1 (way code valid) |
| wr_issue | input | 1 | Write buffer issues its head entry to L2 |
| rd_miss | input | 1 | L1 read miss is sent to L2 this cycle |
| way_en | output | 4 | Per-way L2 enable lines |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
Directed sequences fill the queue with every way code, first as hits and then as misses. Issuing them then separates one-hot decoding from all-ways fallback, and shows whether the push order is kept. Pushes while full, issues while empty, combined push and issue at full and half occupancy, and read misses colliding with issues each isolate one queue rule. A long pseudo-random stream of all five controls, compared each cycle against a queue model, shows up ordering faults, flag miscounts and priority errors that the directed cases do not reach.

// File: rtl/l2ws_pkg.sv
package l2ws_pkg;

    localparam int WAYS   = 4;
    localparam int CODE_W = $clog2(WAYS);

    typedef logic [CODE_W-1:0] way_code_t;
    typedef logic [WAYS-1:0]   way_mask_t;

    typedef struct packed {
        logic      hit;
        way_code_t code;
    } wtag_entry_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WR_ONE,
        ACC_WR_ALL,
        ACC_RD_ALL
    } acc_kind_t;

    function automatic way_mask_t code_to_mask(way_code_t c);
        way_mask_t m;
        for (int i = 0; i < WAYS; i++) begin
            m[i] = (c == way_code_t'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/wtag_fifo.sv
module wtag_fifo
    import l2ws_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_req,
    input  wtag_entry_t push_data,
    input  logic        pop_req,
    output wtag_entry_t head,
    output logic        pop_ack,
    output logic        full,
    output logic        empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wtag_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ack;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign pop_ack  = pop_req && !empty;
    assign push_ack = push_req && (!full || pop_ack);
    assign head     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ack) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ack) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ack)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ack, pop_ack})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R6
    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        full && push_req && !pop_req |=> full); // R7
    AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (rst)
        empty && pop_req && !push_req |=> empty); // R8
    AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        push_req && pop_req && !empty |=> $stable(count)); // R9

endmodule

// File: rtl/way_decoder.sv
module way_decoder
    import l2ws_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_req,
    input  logic        wr_go,
    input  wtag_entry_t entry,
    output way_mask_t   en
);
    acc_kind_t kind;
    way_mask_t one_hot;

    always_comb begin
        if (rd_req)           kind = ACC_RD_ALL;
        else if (!wr_go)      kind = ACC_NONE;
        else if (entry.hit)   kind = ACC_WR_ONE;
        else                  kind = ACC_WR_ALL;
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign one_hot[g] = code_to_mask(entry.code)[g];
    end

    always_comb begin
        unique case (kind)
            ACC_WR_ONE:             en = one_hot;
            ACC_WR_ALL, ACC_RD_ALL: en = '1;
            default:                en = '0;
        endcase
    end

    AST_HIT_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        wr_go && !rd_req && entry.hit |-> $onehot(en)); // R2
    AST_MISS_ALL_WAYS: assert property (@(posedge clk) disable iff (rst)
        wr_go && !entry.hit |-> $countones(en) == WAYS); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wr_go && !rd_req |-> en == '0); // R5

endmodule

// File: rtl/l2_way_steer.sv
module l2_way_steer
    import l2ws_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_push,
    input  logic [CODE_W-1:0] push_code,
    input  logic             push_hit,
    input  logic             wr_issue,
    input  logic             rd_miss,
    output logic [WAYS-1:0]  way_en,
    output logic             q_full,
    output logic             q_empty
);
    wtag_entry_t in_entry, head_entry;
    logic        pop_req, pop_ack;

    assign in_entry = '{hit: push_hit, code: push_code};
    assign pop_req  = wr_issue && !rd_miss;

    wtag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wb_push),
        .push_data (in_entry),
        .pop_req   (pop_req),
        .head      (head_entry),
        .pop_ack   (pop_ack),
        .full      (q_full),
        .empty     (q_empty)
    );

    way_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .rd_req(rd_miss),
        .wr_go (pop_ack),
        .entry (head_entry),
        .en    (way_en)
    );

    AST_RD_ALL_WAYS: assert property (@(posedge clk) disable iff (rst)
        rd_miss |-> way_en == '1); // R4
    AST_RD_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst)
        rd_miss && wr_issue && !q_empty |=> !q_empty); // R10
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty)); // R6

endmodule

// File: tb/l2_way_steer_tb.sv
module l2_way_steer_tb;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       wb_push, push_hit, wr_issue, rd_miss;
    logic [1:0] push_code;
    logic [3:0] way_en;
    logic       q_full, q_empty;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [2:0] mq[$];   // {hit, code[1:0]}

    always #2.5 clk = ~clk;

    l2_way_steer #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .wb_push(wb_push), .push_code(push_code),
        .push_hit(push_hit), .wr_issue(wr_issue), .rd_miss(rd_miss),
        .way_en(way_en), .q_full(q_full), .q_empty(q_empty)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mask(logic [2:0] e);
        return e[2] ? (1 << e[1:0]) : 15;
    endfunction

    // one cycle: drive after negedge, check before posedge, update model
    task automatic step(bit p, int c, bit h, bit o, bit r, string tag);
        string rq;
        int    ex;
        int    n;
        bit    dpop, dpush;
        @(negedge clk);
        wb_push = p; push_code = 2'(c); push_hit = h; wr_issue = o; rd_miss = r;
        #1;
        n = mq.size();
        if (r)                begin ex = 15; rq = "R4"; end
        else if (o && n > 0)  begin ex = exp_mask(mq[0]); rq = mq[0][2] ? "R2" : "R3"; end
        else                  begin ex = 0; rq = "R5"; end
        chk({rq, "/", tag, " way_en"}, int'(way_en), ex);
        chk({"R6/", tag, " full"},  int'(q_full),  int'(n == D));
        chk({"R6/", tag, " empty"}, int'(q_empty), int'(n == 0));
        dpop  = o && !r && n > 0;
        dpush = p && (n < D || dpop);
        if (dpop)  void'(mq.pop_front());
        if (dpush) mq.push_back({h, 2'(c)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        rst = 1; wb_push = 0; push_code = 0; push_hit = 0; wr_issue = 0; rd_miss = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        chk("R1 empty", int'(q_empty), 1);
        chk("R1 full",  int'(q_full), 0);
        chk("R1 way_en", int'(way_en), 0);

        // R8: issue while empty ignored, later push issues normally
        step(0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
        step(1, 2, 1, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");

        for (int pass = 0; pass < 2; pass++) begin
            // fill with all codes; pass 0 hits (R2), pass 1 misses (R3)
            for (int k = 0; k < D; k++) step(1, k, pass == 0, 0, 0, "R6");
            // R7: push while full ignored
            step(1, 1, 0, 0, 0, "R7");
            step(1, 3, 1, 0, 0, "R7");
            // R10: read miss collides with issue; head stays
            step(0, 0, 0, 1, 1, "R10");
            step(0, 0, 0, 1, 1, "R10");
            // R9: push with pop at full keeps occupancy
            step(1, pass ? 0 : 3, 1, 1, 0, "R9");
            step(0, 0, 0, 0, 0, "R9");
            // drain in order
            for (int k = 0; k < D; k++) step(0, 0, 0, 1, 0, "R6");
        end

        // R9 at partial occupancy
        step(1, 1, 1, 0, 0, "R9");
        step(1, 2, 1, 1, 0, "R9");
        step(1, 3, 0, 1, 0, "R9");
        step(0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 1, 0, "R9");

        // pseudo-random sweep of all controls
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[7], int'(lfsr[2:1]), lfsr[3], lfsr[4] | lfsr[9],
                 lfsr[5] & lfsr[6], "mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule